// File: doc/BRIEF.md
# Video Sync and Blank Level Controller

This block sits in the pixel path of a video output stage. On every pixel clock edge where the load qualifier is high, it captures three things together: the per-pixel control inputs (composite sync, blank and an active-low tri-level sync request) and a colour sample for red, green and blue. It carries all of them through one delay line of fixed depth. At the end of the line it produces two results for each colour channel: the delayed pixel sample and a 2-bit level select. The level select tells a downstream current source whether to show video, the blank level, the sync level or the tri-level sync level.

Sync can be inserted on any mix of the three channels, because each channel has its own enable. A global enable lets the tri-level request override the enabled channels. The block also has a separate digital composite sync output. It leaves the same stage as the level selects, so it lines up with them exactly. It works whatever the channel enables are, so a monitor can take sync from this pin when no channel carries it.

Top module: `vsb_ctrl`

## Requirements
- R1: When `load_en` is high at a clock edge, the controls and the three pixel samples are captured together. They appear on `pix_*_o`, `lvl_*_o` and `sync_o` exactly `DEPTH` clock edges later (default 4). This applies whether or not `load_en` is high on the edges in between.
- R2: Level select codes are: 2'b00 video, 2'b01 blank level, 2'b10 sync level, 2'b11 tri-level sync.
- R3: A captured `blank_i` of 1 drives every channel to code 2'b01, unless a higher-priority condition holds for that channel.
- R4: A captured `sync_i` of 1 drives a channel to code 2'b10 only when that channel's enable (`cfg_sync_en_r`, `cfg_sync_en_g`, `cfg_sync_en_b`) is 1. Each enable acts only on its own channel.
- R5: When all three channel enables are 0, `sync_i` has no effect on any level select or pixel output.
- R6: `sync_o` equals the captured `sync_i` with the same delay as the level selects, whatever the values of the channel enables and the tri-level enable.
- R7: When `cfg_tri_en` is 1 and the captured `tri_n_i` is 0, every channel whose sync enable is 1 shows code 2'b11. This holds regardless of the captured sync and blank.
- R8: The priority per channel is tri-level, then sync, then blank, then video.
- R9: When `load_en` is low at an edge, the capture stage keeps its previous sample. That sample keeps emerging from the output `DEPTH-1` edges after it reaches the capture stage.
- R10: Configuration inputs act at the output stage with no delay. A change is visible on `lvl_*_o` in the same cycle.
- R11: A clock edge with `rst_n` low clears every stage. After it, every `lvl_*_o` is 2'b01, `sync_o` is 0 and every `pix_*_o` is 0, until newly captured data reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Capture qualifier for controls and pixel data |
| sync_i | input | 1 | Composite sync request, active high |
| blank_i | input | 1 | Blank request, active high |
| tri_n_i | input | 1 | Tri-level sync request, active low |
| pix_r_i | input | DW | Red pixel sample |
| pix_g_i | input | DW | Green pixel sample |
| pix_b_i | input | DW | Blue pixel sample |
| cfg_sync_en_r | input | 1 | Sync insertion enable, red |
| cfg_sync_en_g | input | 1 | Sync insertion enable, green |
| cfg_sync_en_b | input | 1 | Sync insertion enable, blue |
| cfg_tri_en | input | 1 | Tri-level sync enable |
| pix_r_o | output | DW | Delayed red sample |
| pix_g_o | output | DW | Delayed green sample |
| pix_b_o | output | DW | Delayed blue sample |
| lvl_r_o | output | 2 | Red level select |
| lvl_g_o | output | 2 | Green level select |
| lvl_b_o | output | 2 | Blue level select |
| sync_o | output | 1 | Delay-matched digital composite sync |

## Verification
The bench sweeps every combination of the channel enables against random sync, blank and tri-level traffic. A design that swapped two enables, or let sync leak onto a disabled channel, would show code 2'b10 on the wrong output. The bench also runs long gaps with `load_en` low. A stage that advanced without the qualifier, or a `sync_o` that was one stage off from the level selects, would miscompare at the first edge. A mid-stream reset and stacked sync, blank and tri-level requests target the priority order and the blank-level reset state. A swapped priority shows up as 2'b01 or 2'b10 where 2'b11 is due.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    localparam int NUM_CH = 3;

    // level select driven to each channel's current source
    typedef enum logic [1:0] {
        LVL_VIDEO = 2'b00,
        LVL_BLANK = 2'b01,
        LVL_SYNC  = 2'b10,
        LVL_TRI   = 2'b11
    } lvl_e;

    // per-pixel control bits as carried through the delay line
    typedef struct packed {
        logic sync;
        logic blank;
        logic tri_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam ctl_t CTL_RESET = '{sync: 1'b0, blank: 1'b1, tri_n: 1'b1};

endpackage

// File: rtl/vsb_delay_line.sv
module vsb_delay_line #(
    parameter int             W       = 8,
    parameter int             DEPTH   = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // first stage is the capture stage, qualified by the load strobe
        if (ld) begin
            st_d.stg[0] = din;
        end
        for (int i = 1; i < DEPTH; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.stg[i] = RST_VAL;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.stg[LAST];

    // R1: a qualified edge places the input sample in the capture stage
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (st_q.stg[0] == $past(din)));

    // R9: an unqualified edge leaves the capture stage untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && rst_n) |=> $stable(st_q.stg[0]));

    // R1: every stage beyond capture advances unconditionally
    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (st_q.stg[1] == $past(st_q.stg[0])));

endmodule

// File: rtl/vsb_level_dec.sv
module vsb_level_dec
    import vsb_pkg::*;
(
    input  ctl_t  ctl,
    input  logic  ch_sync_en,
    input  logic  tri_en,
    output lvl_e  lvl
);

    logic tri_hit;
    logic sync_hit;

    always_comb begin
        tri_hit  = tri_en && !ctl.tri_n && ch_sync_en;
        sync_hit = ctl.sync && ch_sync_en;
        if (tri_hit) begin
            lvl = LVL_TRI;
        end else if (sync_hit) begin
            lvl = LVL_SYNC;
        end else if (ctl.blank) begin
            lvl = LVL_BLANK;
        end else begin
            lvl = LVL_VIDEO;
        end
    end

    // R4: a disabled channel never leaves the video/blank pair
    always_comb begin
        a_r4_gate: assert (ch_sync_en || (lvl == LVL_VIDEO) || (lvl == LVL_BLANK));
    end

endmodule

// File: rtl/vsb_ctrl.sv
module vsb_ctrl
    import vsb_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          sync_i,
    input  logic          blank_i,
    input  logic          tri_n_i,
    input  logic [DW-1:0] pix_r_i,
    input  logic [DW-1:0] pix_g_i,
    input  logic [DW-1:0] pix_b_i,
    input  logic          cfg_sync_en_r,
    input  logic          cfg_sync_en_g,
    input  logic          cfg_sync_en_b,
    input  logic          cfg_tri_en,
    output logic [DW-1:0] pix_r_o,
    output logic [DW-1:0] pix_g_o,
    output logic [DW-1:0] pix_b_o,
    output logic [1:0]    lvl_r_o,
    output logic [1:0]    lvl_g_o,
    output logic [1:0]    lvl_b_o,
    output logic          sync_o
);

    localparam int PIX_W  = NUM_CH * DW;
    localparam int LINE_W = CTL_W + PIX_W;
    localparam logic [LINE_W-1:0] LINE_RST = {CTL_RESET, {PIX_W{1'b0}}};

    ctl_t                      ctl_in;
    ctl_t                      ctl_out;
    logic [NUM_CH-1:0][DW-1:0] pix_in;
    logic [NUM_CH-1:0][DW-1:0] pix_out;
    logic [NUM_CH-1:0]         ch_en;
    lvl_e                      lvl [NUM_CH];
    logic [LINE_W-1:0]         line_in;
    logic [LINE_W-1:0]         line_out;

    always_comb begin
        ctl_in.sync  = sync_i;
        ctl_in.blank = blank_i;
        ctl_in.tri_n = tri_n_i;
        pix_in[0]    = pix_r_i;
        pix_in[1]    = pix_g_i;
        pix_in[2]    = pix_b_i;
        ch_en        = {cfg_sync_en_b, cfg_sync_en_g, cfg_sync_en_r};
        line_in      = {ctl_in, pix_in};
    end

    // controls and pixels share one line so their delays cannot diverge
    vsb_delay_line #(
        .W       (LINE_W),
        .DEPTH   (DEPTH),
        .RST_VAL (LINE_RST)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (load_en),
        .din   (line_in),
        .dout  (line_out)
    );

    always_comb begin
        ctl_out = ctl_t'(line_out[LINE_W-1 -: CTL_W]);
        pix_out = line_out[PIX_W-1:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        vsb_level_dec u_dec (
            .ctl        (ctl_out),
            .ch_sync_en (ch_en[c]),
            .tri_en     (cfg_tri_en),
            .lvl        (lvl[c])
        );
    end

    assign pix_r_o = pix_out[0];
    assign pix_g_o = pix_out[1];
    assign pix_b_o = pix_out[2];
    assign lvl_r_o = lvl[0];
    assign lvl_g_o = lvl[1];
    assign lvl_b_o = lvl[2];
    assign sync_o  = ctl_out.sync;

    // R4: a sync code on any channel implies the digital sync is active
    a_r4_sync_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_r_o == 2'b10) || (lvl_g_o == 2'b10) || (lvl_b_o == 2'b10)) |-> sync_o);

    // R5: with no channel enabled only video and blank codes appear
    a_r5_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sync_en_r && !cfg_sync_en_g && !cfg_sync_en_b) |->
        (!lvl_r_o[1] && !lvl_g_o[1] && !lvl_b_o[1]));

    // R7: tri-level needs the global enable
    a_r7_tri_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tri_en |-> ((lvl_r_o != 2'b11) && (lvl_g_o != 2'b11) && (lvl_b_o != 2'b11)));

    // R11: one reset edge leaves blank levels and no sync at the outputs
    a_r11_reset: assert property (@(posedge clk)
        !rst_n |=> ((lvl_r_o == 2'b01) && (lvl_g_o == 2'b01) && (lvl_b_o == 2'b01)
                    && !sync_o && (pix_g_o == '0)));

endmodule

// File: tb/vsb_ctrl_tb.sv
module vsb_ctrl_tb;

    localparam int  DW      = 8;
    localparam int  DEPTH   = 4;
    localparam time CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic          sync_i = 1'b0;
    logic          blank_i = 1'b0;
    logic          tri_n_i = 1'b1;
    logic [DW-1:0] pix_r_i = '0;
    logic [DW-1:0] pix_g_i = '0;
    logic [DW-1:0] pix_b_i = '0;
    logic          cfg_sync_en_r = 1'b0;
    logic          cfg_sync_en_g = 1'b0;
    logic          cfg_sync_en_b = 1'b0;
    logic          cfg_tri_en = 1'b0;
    logic [DW-1:0] pix_r_o, pix_g_o, pix_b_o;
    logic [1:0]    lvl_r_o, lvl_g_o, lvl_b_o;
    logic          sync_o;

    int n_vec  = 0;
    int n_fail = 0;
    int n_cyc  = 0;

    always #(CLK_PER/2) clk = ~clk;

    vsb_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_en       (load_en),
        .sync_i        (sync_i),
        .blank_i       (blank_i),
        .tri_n_i       (tri_n_i),
        .pix_r_i       (pix_r_i),
        .pix_g_i       (pix_g_i),
        .pix_b_i       (pix_b_i),
        .cfg_sync_en_r (cfg_sync_en_r),
        .cfg_sync_en_g (cfg_sync_en_g),
        .cfg_sync_en_b (cfg_sync_en_b),
        .cfg_tri_en    (cfg_tri_en),
        .pix_r_o       (pix_r_o),
        .pix_g_o       (pix_g_o),
        .pix_b_o       (pix_b_o),
        .lvl_r_o       (lvl_r_o),
        .lvl_g_o       (lvl_g_o),
        .lvl_b_o       (lvl_b_o),
        .sync_o        (sync_o)
    );

    // behavioural reference: captured word plus a history queue
    typedef struct {
        bit          s;
        bit          bl;
        bit          tn;
        bit [DW-1:0] r;
        bit [DW-1:0] g;
        bit [DW-1:0] bu;
    } smp_t;

    smp_t rst_smp = '{s: 0, bl: 1, tn: 1, r: 0, g: 0, bu: 0};
    smp_t cap;
    smp_t hist[$];

    function automatic bit [1:0] exp_lvl(smp_t x, bit en);
        if (cfg_tri_en && !x.tn && en) return 2'd3;   // R7, R8
        if (x.s && en)                 return 2'd2;   // R4
        if (x.bl)                      return 2'd1;   // R3
        return 2'd0;
    endfunction

    function automatic string lvl_req(bit [1:0] v);
        case (v)
            2'd3:    return "R7/R8";
            2'd2:    return "R4";
            2'd1:    return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic cmp_lvl(string ch, logic [1:0] act, bit [1:0] exp);
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s lvl_%s act=%b exp=%b t=%0t", lvl_req(exp), ch, act, exp, $time);
        end
    endtask

    task automatic cmp_pix(string ch, logic [DW-1:0] act, bit [DW-1:0] exp);
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R1 pix_%s act=%h exp=%h t=%0t", ch, act, exp, $time);
        end
    endtask

    // one clock: model updates from the inputs held over the edge, then compare
    task automatic step();
        smp_t in_s;
        bit   ld, rs;
        in_s = '{s: sync_i, bl: blank_i, tn: tri_n_i, r: pix_r_i, g: pix_g_i, bu: pix_b_i};
        ld = load_en;
        rs = rst_n;
        @(posedge clk);
        @(negedge clk);
        n_cyc++;
        if (!rs) begin
            cap = rst_smp;
            hist.delete();
            for (int i = 0; i < DEPTH; i++) hist.push_back(rst_smp);
        end else begin
            if (ld) cap = in_s;          // R1 capture, R9 hold
            hist.push_front(cap);
            void'(hist.pop_back());
        end
        n_vec++;
        cmp_lvl("r", lvl_r_o, exp_lvl(hist[DEPTH-1], cfg_sync_en_r));
        cmp_lvl("g", lvl_g_o, exp_lvl(hist[DEPTH-1], cfg_sync_en_g));
        cmp_lvl("b", lvl_b_o, exp_lvl(hist[DEPTH-1], cfg_sync_en_b));
        cmp_pix("r", pix_r_o, hist[DEPTH-1].r);
        cmp_pix("g", pix_g_o, hist[DEPTH-1].g);
        cmp_pix("b", pix_b_o, hist[DEPTH-1].bu);
        // R6: sync_o independent of all enables
        if (sync_o !== hist[DEPTH-1].s) begin
            n_fail++;
            $display("FAIL R6 sync_o act=%b exp=%b t=%0t", sync_o, hist[DEPTH-1].s, $time);
        end
    endtask

    task automatic rand_in(int p_load, int p_sync, int p_blank, int p_tri);
        load_en = ($urandom_range(99) < p_load);
        sync_i  = ($urandom_range(99) < p_sync);
        blank_i = ($urandom_range(99) < p_blank);
        tri_n_i = !($urandom_range(99) < p_tri);
        pix_r_i = DW'($urandom);
        pix_g_i = DW'($urandom);
        pix_b_i = DW'($urandom);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) hist.push_back(rst_smp);
        cap = rst_smp;
        // R11: reset state with noisy inputs present
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rand_in(100, 80, 20, 50);
            cfg_sync_en_r = 1; cfg_sync_en_g = 1; cfg_sync_en_b = 1; cfg_tri_en = 1;
            step();
        end
        if (lvl_r_o !== 2'b01 || lvl_g_o !== 2'b01 || lvl_b_o !== 2'b01 || sync_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset outputs act=%b%b%b/%b exp=010101/0",
                     lvl_r_o, lvl_g_o, lvl_b_o, sync_o);
        end
        rst_n = 1'b1;

        // R1: exact latency with a single marked sample
        cfg_tri_en = 0;
        load_en = 1; sync_i = 0; blank_i = 0; tri_n_i = 1;
        pix_r_i = 8'h5a; pix_g_i = 8'ha5; pix_b_i = 8'h3c;
        step();
        load_en = 0;
        for (int i = 0; i < DEPTH - 1; i++) step();
        if (pix_g_o !== 8'ha5) begin
            n_fail++;
            $display("FAIL R1 latency pix_g act=%h exp=a5", pix_g_o);
        end

        // R4, R5, R6, R8: every enable combination, random traffic
        for (int m = 0; m < 16; m++) begin
            {cfg_tri_en, cfg_sync_en_b, cfg_sync_en_g, cfg_sync_en_r} = 4'(m);
            for (int i = 0; i < 200; i++) begin
                rand_in(100, 40, 40, 30);
                step();
            end
        end

        // R9: sparse load strobe, capture must hold between strobes
        cfg_sync_en_r = 1; cfg_sync_en_g = 0; cfg_sync_en_b = 1; cfg_tri_en = 1;
        for (int i = 0; i < 1500; i++) begin
            rand_in(15, 50, 50, 30);
            step();
        end

        // R10: configuration flips while the line is frozen on a sync+tri sample
        load_en = 1; sync_i = 1; blank_i = 1; tri_n_i = 0;
        step();
        load_en = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            {cfg_tri_en, cfg_sync_en_b, cfg_sync_en_g, cfg_sync_en_r} = 4'($urandom);
            step();
        end
        cfg_tri_en = 1; cfg_sync_en_r = 1; cfg_sync_en_g = 0; cfg_sync_en_b = 0;
        #1;
        if (lvl_r_o !== 2'b11 || lvl_g_o !== 2'b01) begin
            n_fail++;
            $display("FAIL R10 same-cycle cfg act=%b/%b exp=11/01", lvl_r_o, lvl_g_o);
        end
        step();

        // R5: enables all off, sync toggles, outputs must not show sync codes
        cfg_sync_en_r = 0; cfg_sync_en_g = 0; cfg_sync_en_b = 0;
        for (int i = 0; i < 400; i++) begin
            rand_in(100, 70, 30, 60);
            step();
        end

        // R11: reset in mid-stream
        cfg_sync_en_r = 1; cfg_sync_en_g = 1; cfg_sync_en_b = 1;
        for (int i = 0; i < 50; i++) begin rand_in(100, 50, 50, 50); step(); end
        rst_n = 0;
        step();
        rst_n = 1;
        for (int i = 0; i < 300; i++) begin rand_in(60, 50, 50, 50); step(); end

        finish_run();
    end

endmodule